// File: doc/BRIEF.md
# Four-Mode Logic Block Observer Register

This block is a parameterised register whose behaviour is chosen by a two-bit mode code. In functional operation it behaves as ordinary flip-flops that capture a parallel word on every clock. For test it can also be cleared to zero or shifted serially as part of a scan chain. Its fourth use is as a multiple-input signature register, which folds a parallel response word into its state on each clock through an XOR feedback network.

If the parallel inputs are held at zero in signature mode, the register runs as a linear feedback shift register and acts as a pseudo-random pattern generator. It must first be given a non-zero seed, because the all-zero state maps onto itself. One register can therefore either drive patterns into logic or compact responses from it, but not both at once. Registers can be chained through the serial pins.

Stage 1 is bit 0 of every parallel vector, and stage W is bit W-1. The mode code is `mode[1:0]`. The default width is 3, with feedback polynomial 1+x^2+x^3.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage becomes 0 and `scan_out` becomes 0 after that edge.
- R2: With mode 2'b11 (load), `data_out` equals the `data_in` value sampled at the previous rising edge.
- R3: With mode 2'b01 (clear), every stage becomes 0 after the edge, whatever `data_in` and `scan_in` are.
- R4: With mode 2'b00 (shift), stage 1 (bit 0) takes `scan_in`, each stage i>1 takes the old value of stage i-1, and `data_in` has no effect.
- R5: With mode 2'b10 (signature), stage 1 becomes `data_in[0]` XOR the parity of the old state masked by `TAPS`, and each stage i>1 becomes `data_in[i-1]` XOR old stage i-1. With the default taps 3'b110, starting from 0, the inputs 3'b011 then 3'b010 give states 3'b011 then 3'b101.
- R6: In signature mode with `data_in` at 0 and default taps, seed 3'b001 steps through 3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100 and returns to 3'b001 on the seventh clock.
- R7: In signature mode with `data_in` at 0, the all-zero state stays at zero.
- R8: `scan_out` always equals the last stage (bit W-1) of `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Mode code: 11 load, 01 clear, 00 shift, 10 signature |
| data_in | input | W | Parallel data or response word; bit 0 feeds stage 1 |
| scan_in | input | 1 | Serial input to stage 1 in shift mode |
| data_out | output | W | Register state; bit 0 is stage 1 |
| scan_out | output | 1 | Last stage, the serial output for chaining |

## Verification
Signature mode is exercised in three ways:
- The two-word worked example from zero checks the direction of the feedback and the stage order.
- A zero-input run from a one-hot seed has to reproduce the full seven-state cycle, which separates the correct taps from near-miss polynomials.
- A zero-input run from zero confirms the lock-up state.

Further mixed response words, checked against an independent next-state model, catch errors in single bit positions. Load, clear and shift modes are run with `data_in` and `scan_in` set to values that would show up if a mode selected the wrong source. The shift sequence is also checked at `scan_out`.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_LOAD  = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_feedback.sv
// Parity of the register state masked by the feedback taps.
module bilbo_feedback #(
  parameter int          W    = 3,
  parameter logic [W-1:0] TAPS = W'(6)
) (
  input  logic [W-1:0] state,
  output logic         fb
);
  logic [W-1:0] masked;
  always_comb begin
    masked = state & TAPS;
    fb = ^masked;
  end
endmodule

// File: rtl/bilbo_stage.sv
// One register stage with its mode multiplexer.
module bilbo_stage
  import bilbo_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  bilbo_mode_e mode,
  input  logic        par_bit,
  input  logic        shift_src,
  input  logic        sig_src,
  output logic        q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_LOAD:  nxt = par_bit;
      MODE_CLEAR: nxt = 1'b0;
      MODE_SHIFT: nxt = shift_src;
      MODE_SIG:   nxt = par_bit ^ sig_src;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = W'(6)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] data_in,
  input  logic         scan_in,
  output logic [W-1:0] data_out,
  output logic         scan_out
);
  localparam int LAST = W - 1;

  bilbo_mode_e  mode_e;
  logic [W-1:0] state;
  logic         fb;

  assign mode_e = bilbo_mode_e'(mode);

  bilbo_feedback #(.W(W), .TAPS(TAPS)) u_fb (
    .state (state),
    .fb    (fb)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      bilbo_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .par_bit   (data_in[0]),
        .shift_src (scan_in),
        .sig_src   (fb),
        .q         (state[0])
      );
    end else begin : g_body
      bilbo_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .par_bit   (data_in[i]),
        .shift_src (state[i-1]),
        .sig_src   (state[i-1]),
        .q         (state[i])
      );
    end
  end

  assign data_out = state;
  assign scan_out = state[LAST];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int           W    = 3,
  parameter logic [W-1:0] TAPS = W'(6)
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   mode,
  input logic [W-1:0] data_in,
  input logic         scan_in,
  input logic [W-1:0] data_out,
  input logic         scan_out
);
  // R1: reset clears the register
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (data_out == '0 && scan_out == 1'b0));

  // R2: load mode captures the parallel word
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b11) |-> data_out == $past(data_in));

  // R3: clear mode zeroes the register
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b01) |-> data_out == '0);

  // R4: shift mode moves the state up by one stage
  a_r4_shift: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b00) |->
      (data_out[0] == $past(scan_in) &&
       data_out[W-1:1] == $past(data_out[W-2:0])));

  // R5: signature mode compacts the input word
  a_r5_signature: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b10) |->
      (data_out[0] == ($past(data_in[0]) ^ (^($past(data_out) & TAPS))) &&
       data_out[W-1:1] == ($past(data_in[W-1:1]) ^ $past(data_out[W-2:0]))));

  // R7: zero state with zero inputs stays at zero
  a_r7_zero_lock: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'b10 && $past(data_in) == '0 &&
     $past(data_out) == '0) |-> data_out == '0);

  // R8: serial output is the last stage
  a_r8_scan_out: assert property (@(posedge clk) disable iff (rst)
    scan_out == data_out[W-1]);
endmodule

bind bilbo_reg bilbo_reg_chk #(.W(W), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .data_in  (data_in),
  .scan_in  (scan_in),
  .data_out (data_out),
  .scan_out (scan_out)
);

// File: tb/bilbo_reg_bench.sv
`timescale 1ns/1ps
module bilbo_reg_bench;
  localparam int W = 3;
  localparam logic [1:0] M_SHIFT = 2'b00;
  localparam logic [1:0] M_CLEAR = 2'b01;
  localparam logic [1:0] M_SIG   = 2'b10;
  localparam logic [1:0] M_LOAD  = 2'b11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = M_LOAD;
  logic [W-1:0] data_in = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] data_out;
  logic         scan_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  bilbo_reg #(.W(W), .TAPS(3'b110)) u_bilbo_reg (
    .clk(clk), .rst(rst), .mode(mode), .data_in(data_in),
    .scan_in(scan_in), .data_out(data_out), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] sig_next(logic [W-1:0] q, logic [W-1:0] z);
    logic [W-1:0] n;
    n[0] = z[0] ^ q[1] ^ q[2];
    n[1] = z[1] ^ q[0];
    n[2] = z[2] ^ q[1];
    return n;
  endfunction

  // Driver: set inputs at falling edge, push the expected result of the next rising edge.
  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] d,
                      input logic s, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    rst = r; mode = m; data_in = d; scan_in = s;
    model = exp;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one rising edge after each push.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (data_out !== e) begin
        failures++;
        $display("FAIL %s data_out actual=%b expected=%b", t, data_out, e);
      end
      checks++;
      if (scan_out !== e[W-1]) begin
        failures++;
        $display("FAIL %s scan_out actual=%b expected=%b", t, scan_out, e[W-1]);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [6];
    pats = '{3'b111, 3'b100, 3'b001, 3'b110, 3'b010, 3'b101};

    // R1: reset with a non-zero word at the inputs
    step(1'b1, M_LOAD, 3'b111, 1'b1, 3'b000, "R1");
    step(1'b1, M_LOAD, 3'b111, 1'b1, 3'b000, "R1");

    // R2: load mode
    step(1'b0, M_LOAD, 3'b101, 1'b0, 3'b101, "R2");
    step(1'b0, M_LOAD, 3'b010, 1'b1, 3'b010, "R2");
    step(1'b0, M_LOAD, 3'b110, 1'b0, 3'b110, "R2");

    // R3: clear mode ignores data_in and scan_in
    step(1'b0, M_LOAD, 3'b111, 1'b0, 3'b111, "R2");
    step(1'b0, M_CLEAR, 3'b111, 1'b1, 3'b000, "R3");

    // R4/R8: shift 1,0,1 with data_in held at all ones
    step(1'b0, M_SHIFT, 3'b111, 1'b1, 3'b001, "R4");
    step(1'b0, M_SHIFT, 3'b111, 1'b0, 3'b010, "R4");
    step(1'b0, M_SHIFT, 3'b111, 1'b1, 3'b101, "R8");
    step(1'b0, M_SHIFT, 3'b000, 1'b1, 3'b011, "R8");

    // R5: worked example from zero
    step(1'b0, M_CLEAR, 3'b000, 1'b0, 3'b000, "R3");
    step(1'b0, M_SIG, 3'b011, 1'b0, 3'b011, "R5");
    step(1'b0, M_SIG, 3'b010, 1'b1, 3'b101, "R5");

    // R6: pattern generation from seed 3'b001
    step(1'b0, M_LOAD, 3'b001, 1'b0, 3'b001, "R2");
    step(1'b0, M_SIG, 3'b000, 1'b0, 3'b010, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b1, 3'b101, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b0, 3'b011, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b1, 3'b111, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b0, 3'b110, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b0, 3'b100, "R6");
    step(1'b0, M_SIG, 3'b000, 1'b0, 3'b001, "R6");

    // R7: zero lock-up
    step(1'b0, M_CLEAR, 3'b101, 1'b1, 3'b000, "R3");
    for (int k = 0; k < 3; k++) step(1'b0, M_SIG, 3'b000, 1'b1, 3'b000, "R7");

    // R5: mixed response words against the next-state model
    step(1'b0, M_LOAD, 3'b100, 1'b0, 3'b100, "R2");
    for (int k = 0; k < 6; k++)
      step(1'b0, M_SIG, pats[k], 1'b0, sig_next(model, pats[k]), "R5");

    // R1: reset in the middle of signature mode
    step(1'b1, M_SIG, 3'b111, 1'b1, 3'b000, "R1");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule